// File: doc/BRIEF.md
# Latched Status and Interrupt Register Bank

This block is a bank of byte-wide status registers on a simple register bus with a 9-bit address. It watches a vector of monitored signals and offers two views of each one. The real-time view returns the signal's present level. The latched view remembers that the signal moved. Each monitored bit is built to capture a rising edge, a falling edge or both, and this choice is made per bit through parameters. A set latched bit whose interrupt-enable bit is 1 drives the single interrupt request output.

Most latched bits are cleared by writing 1 to them. A separate class of lock-indicator bits is cleared by writing 0 instead, and these bits can never raise the interrupt. Software reads the real-time view, services the latched view and masks the interrupt through an enable register bank. Reserved bit positions and unmapped addresses read as zero. Writes to read-only or unmapped locations change nothing.

Top module: `lsr_status_bank`

## Requirements
- R1: A read of real-time byte k (address 000h+k) returns monitored signals 8k to 8k+7 as sampled one clock before the read strobe, with signal 8k in bit 0 and bit 7 as the MSB.
- R2: A latched bit is set two clocks after its input changes, and only for the edge kinds selected for it: with the defaults, signals 0-3 capture rising edges only, 4-7 falling edges only, and 8-11 both. Reset loads the edge history with the present input level, so no event follows reset.
- R3: For a bit that is not a lock bit, writing 1 to its position in latched byte k (address 040h+k) clears it, and writing 0 leaves it unchanged.
- R4: The interrupt request is high exactly while some latched bit that is not a lock bit is set and its enable bit (address 080h+k, same bit layout) is 1. It is a level and stays high until that bit is cleared or disabled.
- R5: Lock bits (signals 8 and 9 by default) are cleared by writing 0 to their position, writing 1 leaves them unchanged, and they never assert the interrupt request, whatever their enable bits hold.
- R6: When an edge event and a clearing write reach the same latched bit in the same clock, the bit stays set. This holds for both kinds of latched bit.
- R7: Bit positions above the last monitored signal (bits 4-7 of byte 1 by default) read as 0 in every view. Addresses outside the three views, or past the last byte of a view, read as 0. Writes to them, and writes to real-time bytes, have no effect.
- R8: After reset all latched bits and all enable bits read 0 and the interrupt request is low.
- R9: Read data is registered: it is loaded on the clock edge at which the read strobe is high and holds its value until the next read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| addr | input | 9 | Register address, 000h to 1FFh |
| wr_en | input | 1 | Write strobe, one clock per write |
| wr_data | input | 8 | Write data |
| rd_en | input | 1 | Read strobe |
| rd_data | output | 8 | Registered read data |
| sig_in | input | NUM_SIG (12) | Monitored signal vector |
| irq | output | 1 | Level interrupt request |

## Verification
The two functions that can meet in one clock are edge capture and the clearing write to the same latched bit. The bench changes a monitored input on a falling clock edge, waits one cycle so that the detected event is pending, and then issues the clearing write so that both arrive at the same rising edge. It does this once for a write-1-clear bit and once for a lock bit that clears on a written 0. After the collision the latched byte is read back, and the bit must still be set.

// File: rtl/lsr_pkg.sv
`timescale 1ns/1ps
package lsr_pkg;
  localparam int ADDR_W = 9;
  localparam int DATA_W = 8;
  localparam int IDX_W  = 6;
  localparam int PG_W   = ADDR_W - IDX_W;

  localparam logic [PG_W-1:0] PG_RT  = 3'd0;
  localparam logic [PG_W-1:0] PG_LAT = 3'd1;
  localparam logic [PG_W-1:0] PG_IE  = 3'd2;

  // page number: upper address bits
  function automatic logic [PG_W-1:0] addr_page(input logic [ADDR_W-1:0] a);
    return a[ADDR_W-1:IDX_W];
  endfunction

  // byte index inside a page
  function automatic logic [IDX_W-1:0] addr_index(input logic [ADDR_W-1:0] a);
    return a[IDX_W-1:0];
  endfunction

  // transition test against the selected edge kinds
  function automatic logic edge_hit(input logic cur, input logic prev,
                                    input logic rise_en, input logic fall_en);
    return (cur & ~prev & rise_en) | (~cur & prev & fall_en);
  endfunction

  // next latched value: an event always wins over a clear
  function automatic logic next_latch(input logic cur_bit, input logic hit,
                                      input logic we, input logic wbit,
                                      input logic is_lock);
    logic clr;
    clr = we & (is_lock ? ~wbit : wbit);
    return hit | (cur_bit & ~clr);
  endfunction
endpackage

// File: rtl/lsr_edge_det.sv
`timescale 1ns/1ps
module lsr_edge_det #(
  parameter int N = 12,
  parameter logic [N-1:0] RISE_MASK = '0,
  parameter logic [N-1:0] FALL_MASK = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] sig_in,
  output logic [N-1:0] sig_lvl,
  output logic [N-1:0] evt
);
  import lsr_pkg::*;

  logic [N-1:0] prev_q;

  always_ff @(posedge clk) begin
    sig_lvl <= sig_in;
    if (!rst_n) prev_q <= sig_in;
    else        prev_q <= sig_lvl;
  end

  for (genvar i = 0; i < N; i++) begin : g_bit
    assign evt[i] = edge_hit(sig_lvl[i], prev_q[i], RISE_MASK[i], FALL_MASK[i]);
  end
endmodule

// File: rtl/lsr_latch_bank.sv
`timescale 1ns/1ps
module lsr_latch_bank #(
  parameter int N = 12,
  parameter logic [N-1:0] LOCK_MASK = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] evt,
  input  logic [N-1:0] we,
  input  logic [N-1:0] wbit,
  output logic [N-1:0] lat
);
  import lsr_pkg::*;

  logic [N-1:0] lat_d;

  for (genvar i = 0; i < N; i++) begin : g_bit
    assign lat_d[i] = next_latch(lat[i], evt[i], we[i], wbit[i], LOCK_MASK[i]);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) lat <= '0;
    else        lat <= lat_d;
  end
endmodule

// File: rtl/lsr_reg_if.sv
`timescale 1ns/1ps
module lsr_reg_if #(
  parameter int N = 12
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [lsr_pkg::ADDR_W-1:0] addr,
  input  logic                       wr_en,
  input  logic [lsr_pkg::DATA_W-1:0] wr_data,
  input  logic                       rd_en,
  input  logic [N-1:0]               sig_lvl,
  input  logic [N-1:0]               lat,
  output logic [N-1:0]               lat_we,
  output logic [N-1:0]               wbit,
  output logic [N-1:0]               ie,
  output logic [lsr_pkg::DATA_W-1:0] rd_data
);
  import lsr_pkg::*;

  localparam int NB = (N + DATA_W - 1) / DATA_W;
  localparam int NP = NB * DATA_W;

  logic [PG_W-1:0]   page;
  logic [IDX_W-1:0]  idx;
  logic [N-1:0]      ie_we;
  logic [NP-1:0]     rt_pad, lat_pad, ie_pad;
  logic [DATA_W-1:0] rd_next;

  assign page = addr_page(addr);
  assign idx  = addr_index(addr);

  for (genvar i = 0; i < N; i++) begin : g_bit
    localparam logic [IDX_W-1:0] BI = IDX_W'(i / DATA_W);
    assign lat_we[i] = wr_en && (page == PG_LAT) && (idx == BI);
    assign ie_we[i]  = wr_en && (page == PG_IE)  && (idx == BI);
    assign wbit[i]   = wr_data[i % DATA_W];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) ie <= '0;
    else        ie <= (ie & ~ie_we) | (wbit & ie_we);
  end

  always_comb begin
    rt_pad  = '0;
    lat_pad = '0;
    ie_pad  = '0;
    rt_pad[N-1:0]  = sig_lvl;
    lat_pad[N-1:0] = lat;
    ie_pad[N-1:0]  = ie;
  end

  always_comb begin
    rd_next = '0;
    for (int k = 0; k < NB; k++) begin
      if (idx == IDX_W'(k)) begin
        case (page)
          PG_RT:   rd_next = rt_pad[k*DATA_W +: DATA_W];
          PG_LAT:  rd_next = lat_pad[k*DATA_W +: DATA_W];
          PG_IE:   rd_next = ie_pad[k*DATA_W +: DATA_W];
          default: rd_next = '0;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)     rd_data <= '0;
    else if (rd_en) rd_data <= rd_next;
  end
endmodule

// File: rtl/lsr_status_bank.sv
`timescale 1ns/1ps
module lsr_status_bank #(
  parameter int N = 12,
  parameter logic [N-1:0] RISE_MASK = 12'hF0F,
  parameter logic [N-1:0] FALL_MASK = 12'hFF0,
  parameter logic [N-1:0] LOCK_MASK = 12'h300
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [lsr_pkg::ADDR_W-1:0] addr,
  input  logic                       wr_en,
  input  logic [lsr_pkg::DATA_W-1:0] wr_data,
  input  logic                       rd_en,
  output logic [lsr_pkg::DATA_W-1:0] rd_data,
  input  logic [N-1:0]               sig_in,
  output logic                       irq
);
  logic [N-1:0] sig_lvl;
  logic [N-1:0] evt;
  logic [N-1:0] lat;
  logic [N-1:0] lat_we;
  logic [N-1:0] wbit;
  logic [N-1:0] ie;
  logic [N-1:0] irq_src;

  lsr_edge_det #(.N(N), .RISE_MASK(RISE_MASK), .FALL_MASK(FALL_MASK)) u_edge (
    .clk(clk), .rst_n(rst_n), .sig_in(sig_in), .sig_lvl(sig_lvl), .evt(evt)
  );

  lsr_latch_bank #(.N(N), .LOCK_MASK(LOCK_MASK)) u_latch (
    .clk(clk), .rst_n(rst_n), .evt(evt), .we(lat_we), .wbit(wbit), .lat(lat)
  );

  lsr_reg_if #(.N(N)) u_regs (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .wr_data(wr_data),
    .rd_en(rd_en), .sig_lvl(sig_lvl), .lat(lat), .lat_we(lat_we),
    .wbit(wbit), .ie(ie), .rd_data(rd_data)
  );

  assign irq_src = lat & ie & ~LOCK_MASK;
  assign irq     = |irq_src;
endmodule

// File: rtl/lsr_status_chk.sv
`timescale 1ns/1ps
module lsr_status_chk #(
  parameter int N = 12,
  parameter logic [N-1:0] LOCK_MASK = '0
) (
  input logic         clk,
  input logic         rst_n,
  input logic [8:0]   addr,
  input logic         wr_en,
  input logic         rd_en,
  input logic [7:0]   rd_data,
  input logic         irq,
  input logic [N-1:0] evt,
  input logic [N-1:0] lat
);
  AST_EVT_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    (evt != '0) |=> ((lat & $past(evt)) == $past(evt))); // R2

  AST_QUIET_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en && evt == '0) |=> $stable(lat)); // R3

  AST_IRQ_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !wr_en) |=> irq); // R4

  AST_LOCK_NO_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    ((lat & ~LOCK_MASK) == '0) |-> !irq); // R5

  AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && addr[8:6] > 3'd2) |=> (rd_data == 8'h00)); // R7
endmodule

bind lsr_status_bank lsr_status_chk #(.N(N), .LOCK_MASK(LOCK_MASK)) chk_i (
  .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .rd_en(rd_en),
  .rd_data(rd_data), .irq(irq), .evt(evt), .lat(lat)
);

// File: tb/lsr_status_bank_tb.sv
`timescale 1ns/1ps
module lsr_status_bank_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [8:0]  addr = '0;
  logic        wr_en = 1'b0;
  logic [7:0]  wr_data = '0;
  logic        rd_en = 1'b0;
  logic [7:0]  rd_data;
  logic [11:0] sig_in = 12'h0F0;
  logic        irq;

  int n_tests = 0;
  int n_fail  = 0;

  localparam logic [8:0] RT0 = 9'h000, RT1 = 9'h001;
  localparam logic [8:0] LT0 = 9'h040, LT1 = 9'h041;
  localparam logic [8:0] IE0 = 9'h080, IE1 = 9'h081;

  always #4 clk = ~clk;

  lsr_status_bank dut_i (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .wr_data(wr_data),
    .rd_en(rd_en), .rd_data(rd_data), .sig_in(sig_in), .irq(irq)
  );

  task automatic chk(input string req, input logic [7:0] got, input logic [7:0] exp);
    n_tests++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %02h expected %02h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [8:0] a, input logic [7:0] d);
    @(negedge clk);
    addr = a; wr_data = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd_chk(input string req, input logic [8:0] a, input logic [7:0] exp);
    @(negedge clk);
    addr = a; rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
    chk(req, rd_data, exp);
  endtask

  task automatic set_sig(input logic [11:0] v);
    @(negedge clk);
    sig_in = v;
    @(negedge clk);
    @(negedge clk);
  endtask

  task automatic clear_all();
    wr(LT0, 8'hFF);
    wr(LT1, 8'hFC);
  endtask

  task automatic t_reset();
    chk("R8 irq after reset", {7'b0, irq}, 8'h00);
    rd_chk("R8 latched byte 0", LT0, 8'h00);
    rd_chk("R8 latched byte 1", LT1, 8'h00);
    rd_chk("R8 enable byte 0", IE0, 8'h00);
    rd_chk("R1 live byte 0 after reset", RT0, 8'hF0);
  endtask

  task automatic t_rise();
    set_sig(12'h0FF);
    rd_chk("R2 rising capture", LT0, 8'h0F);
    set_sig(12'h0F0);
    rd_chk("R2 falling ignored on rise-only", LT0, 8'h0F);
    clear_all();
  endtask

  task automatic t_fall_w1c();
    set_sig(12'h000);
    rd_chk("R2 falling capture", LT0, 8'hF0);
    wr(LT0, 8'h00);
    rd_chk("R3 write 0 keeps", LT0, 8'hF0);
    wr(LT0, 8'h30);
    rd_chk("R3 write 1 clears", LT0, 8'hC0);
    wr(LT0, 8'hC0);
    set_sig(12'h0F0);
    rd_chk("R2 rising ignored on fall-only", LT0, 8'h00);
  endtask

  task automatic t_both();
    set_sig(12'h4F0);
    rd_chk("R2 both-edge rise", LT1, 8'h04);
    wr(LT1, 8'h04);
    rd_chk("R3 clear byte 1", LT1, 8'h00);
    set_sig(12'h0F0);
    rd_chk("R2 both-edge fall", LT1, 8'h04);
    clear_all();
  endtask

  task automatic t_lock();
    set_sig(12'h1F0);
    rd_chk("R5 lock bit set", LT1, 8'h01);
    wr(LT1, 8'h01);
    rd_chk("R5 lock write 1 keeps", LT1, 8'h01);
    wr(IE1, 8'hFF);
    rd_chk("R7 enable reserved bits", IE1, 8'h0F);
    chk("R5 lock no irq", {7'b0, irq}, 8'h00);
    wr(LT1, 8'h00);
    rd_chk("R5 lock write 0 clears", LT1, 8'h00);
    set_sig(12'h0F0);
    rd_chk("R5 lock set on fall", LT1, 8'h01);
    chk("R5 enabled lock no irq", {7'b0, irq}, 8'h00);
    wr(IE1, 8'h00);
    clear_all();
  endtask

  task automatic t_irq();
    set_sig(12'h0F1);
    chk("R4 disabled no irq", {7'b0, irq}, 8'h00);
    wr(IE0, 8'h01);
    chk("R4 enable raises irq", {7'b0, irq}, 8'h01);
    repeat (5) @(negedge clk);
    chk("R4 irq holds level", {7'b0, irq}, 8'h01);
    wr(IE0, 8'h00);
    chk("R4 disable drops irq", {7'b0, irq}, 8'h00);
    wr(IE0, 8'h01);
    chk("R4 re-enable raises irq", {7'b0, irq}, 8'h01);
    wr(LT0, 8'h01);
    chk("R4 clear drops irq", {7'b0, irq}, 8'h00);
    wr(IE0, 8'h00);
  endtask

  task automatic t_collide();
    set_sig(12'h0F0);
    rd_chk("R2 bit0 fall ignored", LT0, 8'h00);
    @(negedge clk);
    sig_in = 12'h0F1;
    wr(LT0, 8'h01);
    rd_chk("R6 event beats write-1 clear", LT0, 8'h01);
    @(negedge clk);
    sig_in = 12'h1F1;
    wr(LT1, 8'h00);
    rd_chk("R6 event beats lock clear", LT1, 8'h01);
    clear_all();
    rd_chk("R3 cleared after collision", LT0, 8'h00);
  endtask

  task automatic t_live();
    set_sig(12'h5A3);
    rd_chk("R1 live byte 0", RT0, 8'hA3);
    rd_chk("R1 live byte 1", RT1, 8'h05);
    wr(RT0, 8'h00);
    rd_chk("R7 live write ignored", RT0, 8'hA3);
    clear_all();
  endtask

  task automatic t_unmapped();
    rd_chk("R7 top address", 9'h1FF, 8'h00);
    rd_chk("R7 past last live byte", 9'h002, 8'h00);
    wr(9'h0C0, 8'hFF);
    wr(9'h082, 8'hFF);
    rd_chk("R7 unmapped page", 9'h0C0, 8'h00);
    rd_chk("R7 enable byte 0 untouched", IE0, 8'h00);
    rd_chk("R7 enable byte 1 untouched", IE1, 8'h00);
    chk("R7 no irq", {7'b0, irq}, 8'h00);
  endtask

  task automatic t_hold();
    rd_chk("R9 first read", RT1, 8'h05);
    @(negedge clk);
    addr = RT0;
    repeat (2) @(negedge clk);
    chk("R9 data held without strobe", rd_data, 8'h05);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_rise();
    t_fall_w1c();
    t_both();
    t_lock();
    t_irq();
    t_collide();
    t_live();
    t_unmapped();
    t_hold();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule